// File: doc/BRIEF.md
# Program Counter Flow Sequencer

This block owns the 10-bit instruction address of a small 8-bit controller and chooses the address of the next instruction once per instruction. It runs a fixed two-clock instruction cycle. In the fetch phase the address is held steady for program memory. In the execute phase the decoded control operation for the current instruction is applied, and the new address is loaded at the clock edge that closes that phase. The decode logic supplies an operation code, a conditional marker with its condition-met bit, a one-bit operand and a 10-bit absolute target. A separate return stack receives push and pop requests from this block and returns the popped address.

An external interrupt request passes through a two-flop synchronizer and a pending register. When interrupts are enabled, the block replaces the instruction in the next execute phase with an interrupt entry. The entry saves the address of the instruction it preempted, vectors to the top of the code space and clears the enable flag. Return-from-interrupt restores the saved address, and its operand decides whether interrupts come back on. A synchronous reset returns everything to address zero with interrupts off and tells the stack to empty itself.

Top module: `pcseq_top`

## Requirements
- R1: While `rst` is high, each clock edge sets `fetch_addr` to 000, `int_en` to 0 and `exec_phase` to 0.
- R2: After reset is released, `exec_phase` toggles on every clock edge, so the first cycle after release is an execute cycle. `fetch_addr` changes only at an edge that ends a cycle in which `exec_phase` was 1. `push_req` and `pop_req` are high only while `exec_phase` is 1.
- R3: The step operation (`op`=0), the unused codes 6 and 7, and any operation whose condition fails load `fetch_addr`+1 modulo 1024, so 3FF is followed by 000.
- R4: The jump operation (`op`=1) loads `target`. When `is_cond`=1 it does so only if `cond_met`=1 and otherwise steps. The marker gates only jump, call and return. A jump never raises a push or a pop.
- R5: The call operation (`op`=2), when taken under the same condition rule, raises `push_req` with `push_addr`=`fetch_addr`+1 and loads `target`. A call that is not taken pushes nothing.
- R6: The return operation (`op`=3), when taken, raises `pop_req` and loads `pop_addr`. A return that is not taken pops nothing and steps.
- R7: Return-from-interrupt (`op`=4) always raises `pop_req`, loads `pop_addr` and sets `int_en` to `op_arg`. It ignores `is_cond`.
- R8: The enable-write operation (`op`=5) sets `int_en` to `op_arg` and steps.
- R9: An interrupt entry happens in an execute cycle when the request is pending and `int_en`=1. It raises `push_req` with `push_addr` equal to the current `fetch_addr` and no pop, loads 3FF whatever `op` holds, and clears `int_en`.
- R10: Number the first clock edge at which `irq` is high as edge 1, with `int_en`=1. If the cycle before edge 1 had `exec_phase`=0, `fetch_addr` becomes 3FF at edge 4. If that cycle had `exec_phase`=1, it becomes 3FF at edge 5. It never becomes 3FF earlier through the interrupt.
- R11: While `int_en`=0, a high `irq` has no effect: there is no push and addresses keep stepping.
- R12: `stack_flush` is high exactly while `rst` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op | input | 3 | Decoded control operation for the current instruction |
| is_cond | input | 1 | Operation is conditional |
| cond_met | input | 1 | Condition evaluates true |
| op_arg | input | 1 | One-bit operand for enable-write and return-from-interrupt |
| target | input | 10 | Absolute target address for jump and call |
| irq | input | 1 | Interrupt request, level, not synchronized |
| pop_addr | input | 10 | Address returned by the return stack |
| fetch_addr | output | 10 | Current instruction address |
| exec_phase | output | 1 | High during the execute half of the instruction cycle |
| push_req | output | 1 | Push `push_addr` onto the return stack |
| push_addr | output | 10 | Address to save |
| pop_req | output | 1 | Pop the return stack |
| int_en | output | 1 | Interrupt enable flag |
| stack_flush | output | 1 | Empty the return stack |

## Verification
The assertions assume the decode logic holds `op` and its companions steady across each execute cycle and samples them only when `exec_phase` is high. They also assume that `pop_addr` is meaningful only in a cycle in which a pop is requested. The bench drives every operation at the falling edge inside an execute cycle and returns `op` to step right after it. It moves `irq` only at falling edges, so each phase alignment of the request is placed on purpose. The request is dropped before each return-from-interrupt, so the synchronizer has emptied before interrupts are enabled again.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;
  localparam int PC_W_DEF = 10;

  typedef enum logic [2:0] {
    OP_STEP = 3'd0,
    OP_JUMP = 3'd1,
    OP_CALL = 3'd2,
    OP_RET  = 3'd3,
    OP_RETI = 3'd4,
    OP_IEW  = 3'd5
  } seq_op_e;
endpackage

// File: rtl/pcseq_irq_sync.sv
module pcseq_irq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic irq_in,
  input  logic ie_q,
  input  logic taken,
  output logic pend
);
  logic [STAGES-1:0] chain;
  logic              synced;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= irq_in;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], irq_in};
      end
    end
  endgenerate

  assign synced = chain[STAGES-1];

  // pending request: latched while enabled, dropped on entry or disable
  always_ff @(posedge clk) begin
    if (rst || taken) pend <= 1'b0;
    else              pend <= ie_q & (pend | synced);
  end
endmodule

// File: rtl/pcseq_next_sel.sv
module pcseq_next_sel
  import pcseq_pkg::*;
#(
  parameter int AW = PC_W_DEF
) (
  input  logic          exec,
  input  logic [AW-1:0] pc,
  input  logic          ie_q,
  input  logic          irq_pend,
  input  logic [2:0]    op,
  input  logic          is_cond,
  input  logic          cond_met,
  input  logic          op_arg,
  input  logic [AW-1:0] target,
  input  logic [AW-1:0] pop_addr,
  output logic [AW-1:0] pc_nxt,
  output logic          ie_nxt,
  output logic          push_o,
  output logic [AW-1:0] push_addr_o,
  output logic          pop_o,
  output logic          entry_o
);
  localparam logic [AW-1:0] VEC = '1;

  function automatic logic [AW-1:0] f_step(input logic [AW-1:0] a);
    return a + AW'(1);
  endfunction

  function automatic logic f_go(input logic cond, input logic met);
    return !cond || met;
  endfunction

  logic go;

  always_comb begin
    go          = f_go(is_cond, cond_met);
    entry_o     = exec & irq_pend & ie_q;
    pc_nxt      = pc;
    ie_nxt      = ie_q;
    push_o      = 1'b0;
    push_addr_o = f_step(pc);
    pop_o       = 1'b0;
    if (exec) begin
      if (entry_o) begin
        pc_nxt      = VEC;
        ie_nxt      = 1'b0;
        push_o      = 1'b1;
        push_addr_o = pc;
      end else begin
        pc_nxt = f_step(pc);
        case (op)
          OP_JUMP: if (go) pc_nxt = target;
          OP_CALL: if (go) begin
            pc_nxt = target;
            push_o = 1'b1;
          end
          OP_RET: if (go) begin
            pc_nxt = pop_addr;
            pop_o  = 1'b1;
          end
          OP_RETI: begin
            pc_nxt = pop_addr;
            pop_o  = 1'b1;
            ie_nxt = op_arg;
          end
          OP_IEW:  ie_nxt = op_arg;
          default: pc_nxt = f_step(pc);
        endcase
      end
    end
  end
endmodule

// File: rtl/pcseq_state.sv
module pcseq_state #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] pc_nxt,
  input  logic          ie_nxt,
  output logic [AW-1:0] pc_q,
  output logic          ie_q,
  output logic          phase_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q    <= '0;
      ie_q    <= 1'b0;
      phase_q <= 1'b0;
    end else begin
      pc_q    <= pc_nxt;
      ie_q    <= ie_nxt;
      phase_q <= ~phase_q;
    end
  end
endmodule

// File: rtl/pcseq_top.sv
module pcseq_top
  import pcseq_pkg::*;
#(
  parameter int AW          = PC_W_DEF,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [2:0]    op,
  input  logic          is_cond,
  input  logic          cond_met,
  input  logic          op_arg,
  input  logic [AW-1:0] target,
  input  logic          irq,
  input  logic [AW-1:0] pop_addr,
  output logic [AW-1:0] fetch_addr,
  output logic          exec_phase,
  output logic          push_req,
  output logic [AW-1:0] push_addr,
  output logic          pop_req,
  output logic          int_en,
  output logic          stack_flush
);
  logic [AW-1:0] pc_q, pc_nxt;
  logic          ie_q, ie_nxt, phase_q;
  logic          irq_pend;
  logic          irq_entry;

  pcseq_irq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .irq_in(irq), .ie_q(ie_q),
    .taken(irq_entry), .pend(irq_pend)
  );

  pcseq_next_sel #(.AW(AW)) u_sel (
    .exec(phase_q), .pc(pc_q), .ie_q(ie_q), .irq_pend(irq_pend),
    .op(op), .is_cond(is_cond), .cond_met(cond_met), .op_arg(op_arg),
    .target(target), .pop_addr(pop_addr),
    .pc_nxt(pc_nxt), .ie_nxt(ie_nxt), .push_o(push_req),
    .push_addr_o(push_addr), .pop_o(pop_req), .entry_o(irq_entry)
  );

  pcseq_state #(.AW(AW)) u_state (
    .clk(clk), .rst(rst), .pc_nxt(pc_nxt), .ie_nxt(ie_nxt),
    .pc_q(pc_q), .ie_q(ie_q), .phase_q(phase_q)
  );

  assign fetch_addr  = pc_q;
  assign exec_phase  = phase_q;
  assign int_en      = ie_q;
  assign stack_flush = rst;
endmodule

// File: rtl/pcseq_chk.sv
module pcseq_chk #(
  parameter int AW = 10
) (
  input logic          clk,
  input logic          rst,
  input logic [2:0]    op,
  input logic [AW-1:0] fetch_addr,
  input logic          exec_phase,
  input logic          push_req,
  input logic [AW-1:0] push_addr,
  input logic          pop_req,
  input logic          int_en,
  input logic          entry
);
  localparam logic [AW-1:0] VEC = '1;

  // R1
  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (fetch_addr == '0) && !int_en && !exec_phase);

  // R2
  assert_phase_toggle_R2: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (exec_phase != $past(exec_phase)));

  assert_hold_in_fetch_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(exec_phase)) |-> $stable(fetch_addr));

  assert_stack_only_exec_R2: assert property (@(posedge clk) disable iff (rst)
    (push_req || pop_req) |-> exec_phase);

  // R3
  assert_step_wrap_R3: assert property (@(posedge clk) disable iff (rst)
    (exec_phase && op == 3'd0 && !entry) |=> fetch_addr == AW'($past(fetch_addr) + 1'b1));

  assert_push_pop_excl_R5: assert property (@(posedge clk) disable iff (rst)
    !(push_req && pop_req));

  // R9
  assert_entry_vector_R9: assert property (@(posedge clk) disable iff (rst)
    entry |=> (fetch_addr == VEC) && !int_en);

  assert_entry_saves_R9: assert property (@(posedge clk) disable iff (rst)
    entry |-> push_req && (push_addr == fetch_addr) && !pop_req);

  // R11
  assert_no_entry_disabled_R11: assert property (@(posedge clk) disable iff (rst)
    entry |-> int_en);
endmodule

bind pcseq_top pcseq_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .op(op), .fetch_addr(fetch_addr),
  .exec_phase(exec_phase), .push_req(push_req), .push_addr(push_addr),
  .pop_req(pop_req), .int_en(int_en), .entry(irq_entry)
);

// File: tb/pcseq_top_tb.sv
`timescale 1ns/1ps
module pcseq_top_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] op = 3'd0;
  logic       is_cond = 1'b0, cond_met = 1'b0, op_arg = 1'b0, irq = 1'b0;
  logic [9:0] target = '0, pop_addr = '0;
  logic [9:0] fetch_addr, push_addr;
  logic       exec_phase, push_req, pop_req, int_en, stack_flush;

  int checks = 0;
  int errors = 0;
  logic [9:0] model_pc;

  always #4 clk = ~clk;

  pcseq_top u_dut (
    .clk(clk), .rst(rst), .op(op), .is_cond(is_cond), .cond_met(cond_met),
    .op_arg(op_arg), .target(target), .irq(irq), .pop_addr(pop_addr),
    .fetch_addr(fetch_addr), .exec_phase(exec_phase), .push_req(push_req),
    .push_addr(push_addr), .pop_req(pop_req), .int_en(int_en),
    .stack_flush(stack_flush)
  );

  typedef struct packed {
    logic [2:0] op;
    logic       cnd;
    logic       met;
    logic       arg;
    logic [9:0] tgt;
    logic [9:0] pop;
    logic [9:0] nxt;
    logic       psh;
    logic [9:0] pa;
    logic       pp;
    logic       ie;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t TBL [NV] = '{
    '{3'd0, 1'b0, 1'b0, 1'b0, 10'h000, 10'h000, 10'h001, 1'b0, 10'h000, 1'b0, 1'b0}, // R3 step
    '{3'd1, 1'b0, 1'b0, 1'b0, 10'h3FE, 10'h000, 10'h3FE, 1'b0, 10'h000, 1'b0, 1'b0}, // R4 jump
    '{3'd0, 1'b0, 1'b0, 1'b0, 10'h000, 10'h000, 10'h3FF, 1'b0, 10'h000, 1'b0, 1'b0}, // R3 step
    '{3'd0, 1'b0, 1'b0, 1'b0, 10'h000, 10'h000, 10'h000, 1'b0, 10'h000, 1'b0, 1'b0}, // R3 wrap
    '{3'd1, 1'b1, 1'b0, 1'b0, 10'h100, 10'h000, 10'h001, 1'b0, 10'h000, 1'b0, 1'b0}, // R4 not met
    '{3'd1, 1'b1, 1'b1, 1'b0, 10'h100, 10'h000, 10'h100, 1'b0, 10'h000, 1'b0, 1'b0}, // R4 met
    '{3'd2, 1'b0, 1'b0, 1'b0, 10'h200, 10'h000, 10'h200, 1'b1, 10'h101, 1'b0, 1'b0}, // R5 call
    '{3'd2, 1'b1, 1'b0, 1'b0, 10'h300, 10'h000, 10'h201, 1'b0, 10'h000, 1'b0, 1'b0}, // R5 not taken
    '{3'd3, 1'b1, 1'b0, 1'b0, 10'h000, 10'h055, 10'h202, 1'b0, 10'h000, 1'b0, 1'b0}, // R6 not taken
    '{3'd3, 1'b0, 1'b0, 1'b0, 10'h000, 10'h101, 10'h101, 1'b0, 10'h000, 1'b1, 1'b0}, // R6 return
    '{3'd5, 1'b0, 1'b0, 1'b1, 10'h000, 10'h000, 10'h102, 1'b0, 10'h000, 1'b0, 1'b1}, // R8 enable
    '{3'd5, 1'b0, 1'b0, 1'b0, 10'h000, 10'h000, 10'h103, 1'b0, 10'h000, 1'b0, 1'b0}, // R8 disable
    '{3'd4, 1'b1, 1'b0, 1'b1, 10'h000, 10'h2A0, 10'h2A0, 1'b0, 10'h000, 1'b1, 1'b1}, // R7 marker ignored
    '{3'd6, 1'b1, 1'b1, 1'b0, 10'h000, 10'h000, 10'h2A1, 1'b0, 10'h000, 1'b0, 1'b1}, // R3 unused code
    '{3'd5, 1'b0, 1'b0, 1'b0, 10'h000, 10'h000, 10'h2A2, 1'b0, 10'h000, 1'b0, 1'b0}  // R8 disable
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_exec();
    while (!exec_phase) @(negedge clk);
  endtask

  task automatic do_op(input vec_t v, input string tag);
    wait_exec();
    op = v.op; is_cond = v.cnd; cond_met = v.met; op_arg = v.arg;
    target = v.tgt; pop_addr = v.pop;
    #1;
    check(fetch_addr == model_pc, {tag, " R2 held addr"}, fetch_addr, model_pc);
    check(push_req == v.psh, {tag, " push_req"}, push_req, v.psh);
    if (v.psh) check(push_addr == v.pa, {tag, " push_addr"}, push_addr, v.pa);
    check(pop_req == v.pp, {tag, " pop_req"}, pop_req, v.pp);
    @(posedge clk); @(negedge clk);
    op = 3'd0; is_cond = 1'b0; cond_met = 1'b0; op_arg = 1'b0;
    check(fetch_addr == v.nxt, {tag, " next addr"}, fetch_addr, v.nxt);
    check(int_en == v.ie, {tag, " int_en"}, int_en, v.ie);
    model_pc = v.nxt;
  endtask

  function automatic vec_t mk(input logic [2:0] o, input logic a, input logic [9:0] p,
                              input logic [9:0] n, input logic pp, input logic ie);
    vec_t v;
    v = '{op: o, cnd: 1'b0, met: 1'b0, arg: a, tgt: 10'h0, pop: p,
          nxt: n, psh: 1'b0, pa: 10'h0, pp: pp, ie: ie};
    return v;
  endfunction

  // R9 R10: raise irq now, walk edges to the predicted entry
  task automatic irq_run(output logic [9:0] saved);
    int exp_edge;
    logic p0;
    p0 = exec_phase;
    exp_edge = p0 ? 5 : 4;
    irq = 1'b1;
    saved = model_pc;
    for (int k = 1; k <= exp_edge; k++) begin
      if (k == exp_edge) begin
        op = 3'd1; target = 10'h155;
        #1;
        check(push_req == 1'b1, "R9 entry push_req", push_req, 1);
        check(push_addr == model_pc, "R9 saved address", push_addr, model_pc);
        check(pop_req == 1'b0, "R9 no pop", pop_req, 0);
        saved = model_pc;
      end else begin
        #1;
        check(push_req == 1'b0, "R10 no early push", push_req, 0);
      end
      @(posedge clk); @(negedge clk);
      op = 3'd0;
      if (k < exp_edge) begin
        if ((p0 ^ ((k - 1) % 2 == 1)) == 1'b1) model_pc = model_pc + 10'd1;
        check(fetch_addr == model_pc, "R10 not yet vectored", fetch_addr, model_pc);
      end else begin
        check(fetch_addr == 10'h3FF, "R10 vector at predicted edge", fetch_addr, 10'h3FF);
        check(int_en == 1'b0, "R9 entry clears int_en", int_en, 0);
      end
    end
    irq = 1'b0;
    model_pc = 10'h3FF;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [9:0] sv;
    // R1 R12 reset state
    repeat (3) @(negedge clk);
    check(stack_flush == 1'b1, "R12 flush in reset", stack_flush, 1);
    check(fetch_addr == 10'h0, "R1 addr", fetch_addr, 0);
    check(int_en == 1'b0, "R1 int_en", int_en, 0);
    check(exec_phase == 1'b0, "R1 phase", exec_phase, 0);
    rst = 1'b0;
    #1;
    check(stack_flush == 1'b0, "R12 flush released", stack_flush, 0);
    @(negedge clk);
    check(exec_phase == 1'b1, "R2 first cycle is execute", exec_phase, 1);
    model_pc = 10'h0;

    for (int i = 0; i < NV; i++) do_op(TBL[i], $sformatf("vec%0d", i));

    // R11 requests ignored while disabled
    irq = 1'b1;
    for (int k = 0; k < 8; k++) begin
      #1;
      check(push_req == 1'b0, "R11 no push while disabled", push_req, 0);
      @(negedge clk);
    end
    model_pc = model_pc + 10'd4;
    check(fetch_addr == model_pc, "R11 kept stepping", fetch_addr, model_pc);
    irq = 1'b0;
    repeat (4) @(negedge clk);
    model_pc = model_pc + 10'd2;

    // R9 R10 with request raised in a fetch cycle
    do_op(mk(3'd5, 1'b1, 10'h0, model_pc + 10'd1, 1'b0, 1'b1), "R8 enable");
    irq_run(sv);
    do_op(mk(3'd4, 1'b1, sv, sv, 1'b1, 1'b1), "R7 return from isr");

    // R9 R10 with request raised in an execute cycle
    @(negedge clk);
    irq_run(sv);
    do_op(mk(3'd4, 1'b0, sv, sv, 1'b1, 1'b0), "R7 return, stay disabled");

    // R1 R12 reset mid-run
    do_op(mk(3'd5, 1'b1, 10'h0, model_pc + 10'd1, 1'b0, 1'b1), "R8 enable");
    rst = 1'b1;
    #1;
    check(stack_flush == 1'b1, "R12 flush mid-run", stack_flush, 1);
    @(negedge clk); @(negedge clk);
    check(fetch_addr == 10'h0, "R1 mid-run addr", fetch_addr, 0);
    check(int_en == 1'b0, "R1 mid-run int_en", int_en, 0);
    check(exec_phase == 1'b0, "R1 mid-run phase", exec_phase, 0);
    rst = 1'b0;
    @(negedge clk);
    check(exec_phase == 1'b1, "R2 toggle after release", exec_phase, 1);
    @(negedge clk);
    check(exec_phase == 1'b0, "R2 toggle again", exec_phase, 0);
    check(fetch_addr == 10'h1, "R3 step after reset", fetch_addr, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule